// File: doc/BRIEF.md
# Function Queue Allocation Table

This block holds, for every function of a queue manager (one primary function plus up to 63 virtual ones), the contiguous range of queue numbers that function owns. There is one entry kind for submission contexts and one for completion contexts. Software reaches the table through a small bank of word-wide registers. It loads a direction, an entry kind, a function index and a 64-bit entry image split into a low and a high word. It then clears the ready flag and pulses the launch register. A fixed number of cycles later the table either absorbs the entry image or returns the stored entry into the two word registers, and ready comes back.

A combinational lookup port takes a queue number and names the function that owns it. Several ranges may overlap. In that case the lowest-numbered function with a valid submission range wins. A typical layout gives the primary function 64 queues starting at zero, followed by blocks of 15 queues for each virtual function in turn.

Top module: `fqmap_top`

## Requirements
- R1: After reset the ready register reads 1 and every queue number misses on the lookup port (lk_hit = 0, lk_func = 0).
- R2: Register selects are 0 ready, 1 launch, 2 direction, 3 entry kind, 4 function index, 5 low word and 6 high word. Writing 0 to ready clears it. Writing 1 to launch starts an operation only while ready is 0. A launch while ready is 1 is ignored: the table is unchanged and ready stays 1.
- R3: An accepted launch on clock edge E completes on edge E+4, and ready reads 1 from that edge on. Ready stays 0 on edges E+1 to E+3.
- R4: Direction 0 is write and 1 is read. Kind 0 selects the submission entry. In the 64-bit image (high word in bits 63:32) a submission entry places its 10-bit base queue at bits 37:28, the valid bit at bit 44 and the 10-bit count-minus-one at bits 54:45.
- R5: A submission read returns the stored base, valid and count-minus-one at the R4 positions, with every other bit 0, whatever the word registers held before.
- R6: Kind 1 selects the completion entry, which holds only a valid bit at image bit 28. A completion read returns only that bit. A completion write leaves the submission entry of that function untouched.
- R7: A function index above 63 (the function register keeps 8 bits) leaves the table unchanged, still returns ready to 1, and a read with such an index returns an all-zero image.
- R8: The lookup returns the lowest function index whose submission entry is valid and whose range base to base+count-1 holds the queried number. On a miss, lk_hit = 0 and lk_func = 0. Clearing the valid bit removes the range.
- R9: Count spans 1 to 1024, and a range may reach past queue 1023 without wrapping to low numbers.
- R10: While an operation is in flight, writes to every register are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_sel | input | 3 | Register select |
| cfg_wr | input | 1 | Write strobe for the selected register |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data of the selected register (combinational) |
| lk_queue | input | 10 | Queue number to look up |
| lk_hit | output | 1 | Some valid range holds lk_queue |
| lk_func | output | 6 | Lowest owning function index |

## Verification
The assertions assume that the register bus changes only between clock edges. They also assume that a launch is meaningful only after software has cleared ready. From these they check that completion comes four cycles after the launch, that ready stays low while busy, that the table changes only on a commit, and that any reported hit lies inside the reported function's range. The stimulus drives each register access for one full cycle, starting at a falling edge. It always goes through the clear-then-launch sequence, except in the test that deliberately launches with ready still set.

// File: rtl/fqmap_pkg.sv
package fqmap_pkg;

  localparam int QNUM_W       = 10;
  localparam int SQ_BASE_LSB  = 28;
  localparam int SQ_VALID_BIT = 44;
  localparam int SQ_CNT_LSB   = 45;
  localparam int CQ_VALID_BIT = 28;

  typedef enum logic [2:0] {
    SEL_READY  = 3'd0,
    SEL_LAUNCH = 3'd1,
    SEL_DIR    = 3'd2,
    SEL_KIND   = 3'd3,
    SEL_FUNC   = 3'd4,
    SEL_WLO    = 3'd5,
    SEL_WHI    = 3'd6
  } reg_sel_e;

  typedef struct packed {
    logic [QNUM_W-1:0] base;
    logic [QNUM_W-1:0] cnt_m1;
    logic              sq_v;
    logic              cq_v;
  } fq_entry_t;

  function automatic logic [63:0] sq_pack(input fq_entry_t e);
    logic [63:0] w;
    w = '0;
    w[SQ_BASE_LSB +: QNUM_W] = e.base;
    w[SQ_VALID_BIT]          = e.sq_v;
    w[SQ_CNT_LSB +: QNUM_W]  = e.cnt_m1;
    return w;
  endfunction

  function automatic logic [63:0] cq_pack(input logic v);
    logic [63:0] w;
    w = '0;
    w[CQ_VALID_BIT] = v;
    return w;
  endfunction

  function automatic logic in_range(input logic [QNUM_W-1:0] base,
                                    input logic [QNUM_W-1:0] cnt_m1,
                                    input logic [QNUM_W-1:0] q);
    logic [QNUM_W:0] last;
    last = {1'b0, base} + {1'b0, cnt_m1};
    return ({1'b0, q} >= {1'b0, base}) && ({1'b0, q} <= last);
  endfunction

endpackage

// File: rtl/fqmap_regs.sv
module fqmap_regs
  import fqmap_pkg::*;
#(
  parameter int NUM_FUNC = 64,
  parameter int LATENCY  = 4,
  localparam int FW      = $clog2(NUM_FUNC),
  localparam int FREG_W  = FW + 2,
  localparam int CW      = $clog2(LATENCY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_sel,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [63:0]       rd_word,
  output logic              ready,
  output logic              busy,
  output logic              launch_acc,
  output logic              commit,
  output logic              op_write,
  output logic              kind,
  output logic [FREG_W-1:0] func_idx,
  output logic [63:0]       wr_word
);

  logic          dir_q;
  logic [31:0]   wlo_q, whi_q;
  logic [CW-1:0] cnt_q;

  function automatic logic wr_to(input logic [2:0] s, input reg_sel_e r,
                                 input logic st, input logic bz);
    return st && !bz && (s == r);
  endfunction

  assign launch_acc = wr_to(cfg_sel, SEL_LAUNCH, cfg_wr, busy) && cfg_wdata[0] && !ready;
  assign commit     = busy && (cnt_q == '0);
  assign op_write   = !dir_q;
  assign wr_word    = {whi_q, wlo_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt_q <= '0;
      ready <= 1'b1;
    end else if (launch_acc) begin
      busy  <= 1'b1;
      cnt_q <= CW'(LATENCY - 1);
    end else if (commit) begin
      busy  <= 1'b0;
      ready <= 1'b1;
    end else if (busy) begin
      cnt_q <= cnt_q - 1'b1;
    end else if (wr_to(cfg_sel, SEL_READY, cfg_wr, busy) && !cfg_wdata[0]) begin
      ready <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= 1'b0;
      kind     <= 1'b0;
      func_idx <= '0;
      wlo_q    <= '0;
      whi_q    <= '0;
    end else if (commit && dir_q) begin
      wlo_q <= rd_word[31:0];
      whi_q <= rd_word[63:32];
    end else begin
      if (wr_to(cfg_sel, SEL_DIR,  cfg_wr, busy)) dir_q    <= cfg_wdata[0];
      if (wr_to(cfg_sel, SEL_KIND, cfg_wr, busy)) kind     <= cfg_wdata[0];
      if (wr_to(cfg_sel, SEL_FUNC, cfg_wr, busy)) func_idx <= cfg_wdata[FREG_W-1:0];
      if (wr_to(cfg_sel, SEL_WLO,  cfg_wr, busy)) wlo_q    <= cfg_wdata;
      if (wr_to(cfg_sel, SEL_WHI,  cfg_wr, busy)) whi_q    <= cfg_wdata;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_sel)
      SEL_READY: cfg_rdata[0] = ready;
      SEL_DIR:   cfg_rdata[0] = dir_q;
      SEL_KIND:  cfg_rdata[0] = kind;
      SEL_FUNC:  cfg_rdata[FREG_W-1:0] = func_idx;
      SEL_WLO:   cfg_rdata = wlo_q;
      SEL_WHI:   cfg_rdata = whi_q;
      default:   cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/fqmap_store.sv
module fqmap_store
  import fqmap_pkg::*;
#(
  parameter int NUM_FUNC = 64,
  localparam int FW      = $clog2(NUM_FUNC),
  localparam int FREG_W  = FW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_wr,
  input  logic              kind,
  input  logic [FREG_W-1:0] func_idx,
  input  logic [63:0]       wr_word,
  output logic [63:0]       rd_word,
  output fq_entry_t         tbl [NUM_FUNC]
);

  logic          idx_ok;
  logic [FW-1:0] fidx;
  fq_entry_t     sel_e;

  assign idx_ok = func_idx < FREG_W'(NUM_FUNC);
  assign fidx   = func_idx[FW-1:0];
  assign sel_e  = tbl[fidx];

  for (genvar i = 0; i < NUM_FUNC; i++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tbl[i] <= '0;
      end else if (commit_wr && idx_ok && (fidx == FW'(i))) begin
        if (kind) begin
          tbl[i].cq_v <= wr_word[CQ_VALID_BIT];
        end else begin
          tbl[i].base   <= wr_word[SQ_BASE_LSB +: QNUM_W];
          tbl[i].sq_v   <= wr_word[SQ_VALID_BIT];
          tbl[i].cnt_m1 <= wr_word[SQ_CNT_LSB +: QNUM_W];
        end
      end
    end
  end

  always_comb begin
    if (!idx_ok)   rd_word = '0;
    else if (kind) rd_word = cq_pack(sel_e.cq_v);
    else           rd_word = sq_pack(sel_e);
  end

endmodule

// File: rtl/fqmap_lookup.sv
module fqmap_lookup
  import fqmap_pkg::*;
#(
  parameter int NUM_FUNC = 64,
  localparam int FW      = $clog2(NUM_FUNC)
) (
  input  fq_entry_t         tbl [NUM_FUNC],
  input  logic [QNUM_W-1:0] lk_queue,
  output logic              lk_hit,
  output logic [FW-1:0]     lk_func
);

  logic [NUM_FUNC-1:0] hit_vec;

  for (genvar i = 0; i < NUM_FUNC; i++) begin : g_cmp
    assign hit_vec[i] = tbl[i].sq_v && in_range(tbl[i].base, tbl[i].cnt_m1, lk_queue);
  end

  always_comb begin
    lk_func = '0;
    for (int i = NUM_FUNC - 1; i >= 0; i--) begin
      if (hit_vec[i]) lk_func = FW'(i);
    end
  end

  assign lk_hit = |hit_vec;

endmodule

// File: rtl/fqmap_top.sv
module fqmap_top
  import fqmap_pkg::*;
#(
  parameter int NUM_FUNC = 64,
  parameter int LATENCY  = 4,
  localparam int FW      = $clog2(NUM_FUNC),
  localparam int FREG_W  = FW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cfg_sel,
  input  logic              cfg_wr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic [QNUM_W-1:0] lk_queue,
  output logic              lk_hit,
  output logic [FW-1:0]     lk_func
);

  logic              ready_w, busy_w, launch_w, commit_w, op_write_w, kind_w;
  logic [FREG_W-1:0] func_w;
  logic [63:0]       wr_word_w, rd_word_w;
  fq_entry_t         tbl_w [NUM_FUNC];

  fqmap_regs #(.NUM_FUNC(NUM_FUNC), .LATENCY(LATENCY)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .rd_word(rd_word_w),
    .ready(ready_w), .busy(busy_w), .launch_acc(launch_w), .commit(commit_w),
    .op_write(op_write_w), .kind(kind_w), .func_idx(func_w), .wr_word(wr_word_w)
  );

  fqmap_store #(.NUM_FUNC(NUM_FUNC)) store_i (
    .clk(clk), .rst_n(rst_n), .commit_wr(commit_w && op_write_w), .kind(kind_w),
    .func_idx(func_w), .wr_word(wr_word_w), .rd_word(rd_word_w), .tbl(tbl_w)
  );

  fqmap_lookup #(.NUM_FUNC(NUM_FUNC)) lookup_i (
    .tbl(tbl_w), .lk_queue(lk_queue), .lk_hit(lk_hit), .lk_func(lk_func)
  );

endmodule

// File: rtl/fqmap_checker.sv
module fqmap_checker
  import fqmap_pkg::*;
#(
  parameter int NUM_FUNC = 64,
  parameter int LATENCY  = 4,
  localparam int FW      = $clog2(NUM_FUNC)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ready,
  input logic              busy,
  input logic              launch_acc,
  input logic              commit,
  input fq_entry_t         tbl [NUM_FUNC],
  input logic [QNUM_W-1:0] lk_queue,
  input logic              lk_hit,
  input logic [FW-1:0]     lk_func
);

  logic [7:0] since_q;
  fq_entry_t  own_e;
  logic [QNUM_W:0] own_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_q <= '0;
    else if (launch_acc)       since_q <= '0;
    else if (busy && !commit)  since_q <= since_q + 1'b1;
  end

  assign own_e    = tbl[lk_func];
  assign own_last = {1'b0, own_e.base} + {1'b0, own_e.cnt_m1};

  p_commit_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (since_q == 8'(LATENCY - 1)));

  p_ready_after_commit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> ready);

  p_ready_low_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ready);

  p_launch_needs_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch_acc |=> busy && !ready);

  p_hit_in_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lk_hit |-> own_e.sq_v && ({1'b0, lk_queue} >= {1'b0, own_e.base})
               && ({1'b0, lk_queue} <= own_last));

  for (genvar i = 0; i < NUM_FUNC; i++) begin : g_hold
    p_table_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(tbl[i]));
  end

endmodule

bind fqmap_top fqmap_checker #(.NUM_FUNC(NUM_FUNC), .LATENCY(LATENCY)) chk_i (
  .clk(clk), .rst_n(rst_n), .ready(ready_w), .busy(busy_w),
  .launch_acc(launch_w), .commit(commit_w), .tbl(tbl_w),
  .lk_queue(lk_queue), .lk_hit(lk_hit), .lk_func(lk_func)
);

// File: tb/fqmap_tb_top.sv
`timescale 1ns/1ps
module fqmap_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [9:0]  lk_queue = '0;
  logic        lk_hit;
  logic [5:0]  lk_func;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fqmap_top dut_i (.clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .lk_queue(lk_queue),
    .lk_hit(lk_hit), .lk_func(lk_func));

  // {queue, expected hit, expected function}
  localparam logic [16:0] LK_VEC [14] = '{
    {10'd0,    1'b1, 6'd0}, {10'd63,  1'b1, 6'd0}, {10'd64,  1'b1, 6'd1},
    {10'd78,   1'b1, 6'd1}, {10'd79,  1'b1, 6'd2}, {10'd93,  1'b1, 6'd2},
    {10'd94,   1'b1, 6'd3}, {10'd108, 1'b1, 6'd3}, {10'd109, 1'b0, 6'd0},
    {10'd72,   1'b1, 6'd1}, {10'd1019,1'b0, 6'd0}, {10'd1023,1'b1, 6'd6},
    {10'd200,  1'b1, 6'd7}, {10'd201, 1'b0, 6'd0}
  };

  function automatic logic [63:0] mk_sq(input int b, input int c, input bit v);
    logic [63:0] w;
    w = (64'(b) << 28) | (64'(c - 1) << 45);
    w[44] = v;
    return w;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] v);
    @(negedge clk);
    cfg_sel = s; cfg_wdata = v; cfg_wr = 1'b1;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    cfg_sel = s; #1 v = cfg_rdata;
  endtask

  task automatic launch_wait(input bit timed);
    logic [31:0] v;
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd1);
    cfg_sel = 3'd0;
    repeat (3) @(negedge clk);
    if (timed) begin rd(3'd0, v); chk("R3 ready low at E+3", 64'(v), 64'd0); end
    @(negedge clk);
    if (timed) begin rd(3'd0, v); chk("R3 ready back at E+4", 64'(v), 64'd1); end
  endtask

  task automatic do_op(input bit dir, input bit kind, input int f,
                       input logic [63:0] w, input bit timed);
    wr(3'd2, 32'(dir));
    wr(3'd3, 32'(kind));
    wr(3'd4, 32'(f));
    wr(3'd5, w[31:0]);
    wr(3'd6, w[63:32]);
    launch_wait(timed);
  endtask

  task automatic look(input string req, input int q, input bit h, input int f);
    lk_queue = 10'(q); #1;
    chk(req, {lk_hit, lk_func}, {h, 6'(f)});
  endtask

  task automatic rd_word(output logic [63:0] w);
    logic [31:0] lo, hi;
    rd(3'd5, lo); rd(3'd6, hi);
    w = {hi, lo};
  endtask

  initial begin
    logic [31:0] v;
    logic [63:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(3'd0, v); chk("R1 ready after reset", 64'(v), 64'd1);
    look("R1 no hit after reset", 0, 0, 0);

    // R2: launch with ready still set is ignored
    wr(3'd2, 0); wr(3'd3, 0); wr(3'd4, 0);
    w = mk_sq(0, 64, 1); wr(3'd5, w[31:0]); wr(3'd6, w[63:32]);
    wr(3'd1, 1); repeat (6) @(negedge clk);
    look("R2 launch ignored while ready", 0, 0, 0);
    rd(3'd0, v); chk("R2 ready stays set", 64'(v), 64'd1);

    // R3 timed write of primary function, R4 packing
    do_op(0, 0, 0, mk_sq(0, 64, 1), 1);
    for (int i = 1; i <= 3; i++) do_op(0, 0, i, mk_sq(64 + 15 * (i - 1), 15, 1), 0);
    do_op(0, 0, 5, mk_sq(70, 5, 1), 0);
    do_op(0, 0, 6, mk_sq(1020, 8, 1), 0);
    do_op(0, 0, 7, mk_sq(200, 1, 1), 0);
    foreach (LK_VEC[i]) begin
      look("R8 R9 R4 lookup vector", int'(LK_VEC[i][16:7]), LK_VEC[i][6], int'(LK_VEC[i][5:0]));
    end

    // R5 submission read, word registers preloaded with ones
    do_op(1, 0, 2, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    rd_word(w); chk("R5 submission read image", w, mk_sq(79, 15, 1));

    // R6 completion entry
    do_op(0, 1, 2, 64'h0000_0000_1000_0000, 0);
    do_op(1, 1, 2, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    rd_word(w); chk("R6 completion read image", w, 64'h0000_0000_1000_0000);
    do_op(1, 1, 3, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    rd_word(w); chk("R6 unset completion reads zero", w, 64'd0);
    do_op(1, 0, 2, 64'd0, 0);
    rd_word(w); chk("R6 submission kept after completion write", w, mk_sq(79, 15, 1));
    look("R6 lookup kept", 80, 1, 2);

    // R7 out-of-range function index
    do_op(0, 0, 64, mk_sq(500, 4, 1), 1);
    look("R7 out of range write ignored", 500, 0, 0);
    do_op(1, 0, 64, 64'hFFFF_FFFF_FFFF_FFFF, 0);
    rd_word(w); chk("R7 out of range read zero", w, 64'd0);

    // R10 writes during busy are ignored
    wr(3'd2, 1); wr(3'd3, 0); wr(3'd4, 0);
    wr(3'd0, 0); wr(3'd1, 1);
    wr(3'd5, 32'h0000_1234);
    wr(3'd4, 32'd3);
    repeat (2) @(negedge clk);
    rd_word(w); chk("R10 word image from read, not busy write", w, mk_sq(0, 64, 1));
    rd(3'd4, v); chk("R10 function register unchanged", 64'(v), 64'd0);

    // R8 clearing valid removes the range
    do_op(0, 0, 3, mk_sq(94, 15, 0), 0);
    look("R8 invalidated range misses", 100, 0, 0);
    done = 1;
  end

  initial begin
    fork
      begin repeat (20000) @(posedge clk);
        errors++; checks++; $display("FAIL watchdog: actual timeout expected completion"); end
      wait (done);
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule